// File: doc/BRIEF.md
# Fixed-Direction GPIO with Edge Interrupts

This block is an eight-line general purpose I/O port on a byte-wide register bus. The lower four lines are hard-wired outputs driven from a latch. The upper four lines are hard-wired inputs that pass through a synchroniser. A host talks to the block over a simple synchronous bus with an address, a write strobe, a read strobe, write data and read data. Read data is combinational and is zero whenever the read strobe is low.

Each input line can raise an event on its rising edge, its falling edge or both. Two enable bits per input select the edges. An event sets a sticky pending bit, indexed by input number, and software clears it by writing ones. A single level interrupt output stays high while any pending bit is set. Direction is fixed by hardware. The direction offset exists only so that software written for a programmable port still reads back a sensible value.

Register offsets: 0 = direction (read-only view), 1 = data, 3 = edge configuration, 4 = pending status. All other offsets are unused.

Top module: `gpio_fixdir_irq`

## Requirements
- R1: While reset is asserted and right after it is released, the output latch, the edge configuration, the pending status and irq_o are all 0. An input that is already high at reset release produces no event, even when edges are enabled in the first cycle after reset.
- R2: Offset 0 always reads 0x0F (ones mark the output lines), and writes to it change nothing.
- R3: A write to offset 1 loads wdata_i[3:0] into gpo_o on that clock edge. Bits 7:4 of the write are ignored. gpo_o holds its value in every other cycle.
- R4: A read of offset 1 returns the output latch in bits 3:0 and the synchronised input levels in bits 7:4. A change on gpi_i is first seen there after the second rising clock edge.
- R5: Offset 3 is a read/write byte. For input i, bit 2i enables falling-edge events and bit 2i+1 enables rising-edge events. Both bits set selects both edges, and 00 disables the input.
- R6: An enabled edge on gpi_i[i] (line 4+i) sets pending bit i of offset 4 after the third rising edge following the change, and not earlier. Bits 7:4 of offset 4 read 0.
- R7: Writing offset 4 clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R8: If a new enabled edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R9: irq_o is high exactly while at least one pending bit is set. It falls only after a clearing write.
- R10: With the configuration set to 0, input edges set no pending bit. Bits already pending stay set and can still be cleared.
- R11: Offsets 2, 5, 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_en_i | input | 1 | Read strobe, gates rdata_o |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| gpo_o | output | 4 | Output lines 0..3 |
| gpi_i | input | 4 | Asynchronous input lines 4..7 |
| irq_o | output | 1 | Level interrupt, OR of the pending bits |

## Verification
Each result is due at a known edge:
- A register write is visible at the falling edge right after the rising edge that captured it.
- An input change driven on a falling edge reaches the data register after two rising edges.
- An input change sets a pending bit and irq_o after three rising edges.

The bench drives every stimulus on a falling edge and samples during the low phase of the clock. For every edge case it reads the status one edge before the event is due and expects zero, then reads it one edge later and expects the bit. The same-cycle set and clear is arranged so that the write strobe is active on exactly the edge that captures the event.

// File: rtl/gpio_fixdir_pkg.sv
package gpio_fixdir_pkg;
  localparam int DW          = 8;
  localparam int AW          = 3;
  localparam int GPO_N       = 4;
  localparam int GPI_N       = 4;
  localparam int SYNC_STAGES = 2;
  localparam int CFG_W       = 2 * GPI_N;
  localparam int ARM_CYC     = SYNC_STAGES + 1;
  localparam int ARM_W       = $clog2(ARM_CYC + 1);
  localparam logic [DW-1:0] DIR_VIEW = DW'((1 << GPO_N) - 1);

  localparam logic [AW-1:0] OFF_DIR  = AW'(0);
  localparam logic [AW-1:0] OFF_DATA = AW'(1);
  localparam logic [AW-1:0] OFF_CFG  = AW'(3);
  localparam logic [AW-1:0] OFF_STAT = AW'(4);

  // position of the enable bits inside one configuration pair
  localparam int EDGE_FALL_BIT = 0;
  localparam int EDGE_RISE_BIT = 1;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic arm_i,
  input  logic fall_en_i,
  input  logic rise_en_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, evt;

  assign evt = arm_i & ((rise_en_i & lvl_i & ~prev_q) | (fall_en_i & ~lvl_i & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | evt;  // set wins over clear
    end

  assign pend_o = pend_q;

  assert_set_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(arm_i && (fall_en_i || rise_en_i)));
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !pend_q);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt) |=> pend_q);
endmodule

// File: rtl/gpio_fixdir_irq.sv
module gpio_fixdir_irq
  import gpio_fixdir_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [GPO_N-1:0] gpo_o,
  input  logic [GPI_N-1:0] gpi_i,
  output logic             irq_o
);
  logic [GPO_N-1:0] out_q;
  logic [CFG_W-1:0] cfg_q;
  logic [GPI_N-1:0] lvl, pend, clr;
  logic [ARM_W-1:0] arm_cnt_q;
  logic             armed;
  logic             wr_data, wr_cfg, wr_stat;

  assign wr_data = wr_en_i && (addr_i == OFF_DATA);
  assign wr_cfg  = wr_en_i && (addr_i == OFF_CFG);
  assign wr_stat = wr_en_i && (addr_i == OFF_STAT);
  assign clr     = wr_stat ? wdata_i[GPI_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      out_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_data) out_q <= wdata_i[GPO_N-1:0];
      if (wr_cfg)  cfg_q <= wdata_i[CFG_W-1:0];
    end

  // hold off edge detection until the synchroniser and history flop hold real pin values
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                         arm_cnt_q <= '0;
    else if (arm_cnt_q != ARM_W'(ARM_CYC)) arm_cnt_q <= arm_cnt_q + 1'b1;

  assign armed = (arm_cnt_q == ARM_W'(ARM_CYC));

  gpio_in_sync #(.W(GPI_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpi_i),
    .q_o    (lvl)
  );

  for (genvar i = 0; i < GPI_N; i++) begin : g_edge
    gpio_edge_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl[i]),
      .arm_i     (armed),
      .fall_en_i (cfg_q[2*i + EDGE_FALL_BIT]),
      .rise_en_i (cfg_q[2*i + EDGE_RISE_BIT]),
      .clr_i     (clr[i]),
      .pend_o    (pend[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFF_DIR:  rdata_o = DIR_VIEW;
        OFF_DATA: rdata_o = {lvl, out_q};
        OFF_CFG:  rdata_o = DW'(cfg_q);
        OFF_STAT: rdata_o = DW'(pend);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign gpo_o = out_q;
  assign irq_o = |pend;

  assert_gpo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data |=> $stable(gpo_o));
  assert_cfg_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> (cfg_q == $past(wdata_i[CFG_W-1:0])));
  assert_irq_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_stat));
endmodule

// File: tb/test_gpio_fixdir_irq.sv
`timescale 1ns/1ps
module test_gpio_fixdir_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] gpo;
  logic [3:0] gpi = '0;
  logic       irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_fixdir_irq i_gpio_fixdir_irq (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .gpo_o(gpo), .gpi_i(gpi), .irq_o(irq));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // called in the low phase of the clock
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1; #1; v = rdata; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clear_all();
    logic [7:0] v;
    rd(3'd4, v);
    wr(3'd4, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    // R1: reset state, input held high across reset
    gpi = 4'hF;
    repeat (3) nxt();
    check("R1 gpo in reset", gpo, 0);
    check("R1 irq in reset", irq, 0);
    rd(3'd3, v); check("R1 cfg in reset", v, 0);
    rd(3'd4, v); check("R1 status in reset", v, 0);
    rd(3'd1, v); check("R1 data in reset", v, 0);
    // release with all edges enabled on the very first edge
    nxt(); addr = 3'd3; wdata = 8'hFF; wr_en = 1'b1; rst_n = 1'b1;
    nxt(); wr_en = 1'b0;
    repeat (6) nxt();
    rd(3'd4, v); check("R1 no spurious event", v, 0);
    check("R1 irq quiet", irq, 0);
    gpi = 4'h0;
    repeat (3) nxt();
    rd(3'd4, v); check("R6 all falling", v, 8'h0F);
    check("R9 irq on", irq, 1);
    clear_all();
    check("R9 irq off", irq, 0);
    wr(3'd3, 8'h00);

    // R2: direction fixed
    wr(3'd0, 8'h00); rd(3'd0, v); check("R2 dir after 0x00", v, 8'h0F);
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 dir after 0xFF", v, 8'h0F);
    check("R2 gpo untouched", gpo, 0);

    // R3 / R4: output latch sweep
    for (int o = 0; o < 16; o++) begin
      wr(3'd1, 8'((((~o) & 15) << 4) | o));
      check("R3 gpo", gpo, o);
      rd(3'd1, v); check("R4 data low nibble", v, o);
      repeat (2) nxt();
      check("R3 gpo hold", gpo, o);
    end
    // R4: input level sweep with two-edge latency
    for (int n = 0; n < 16; n++) begin
      int prev_lvl;
      prev_lvl = int'(gpi);
      gpi = 4'(n);
      nxt(); rd(3'd1, v); check("R4 input one edge", v, (prev_lvl << 4) | 15);
      nxt(); rd(3'd1, v); check("R4 input two edges", v, (n << 4) | 15);
    end
    gpi = 4'h0; repeat (4) nxt();

    // R5: configuration read/write sweep
    for (int c = 0; c < 256; c++) begin
      wr(3'd3, 8'(c)); rd(3'd3, v); check("R5 cfg readback", v, c);
    end
    wr(3'd3, 8'h00);
    clear_all();

    // R5 / R6 / R7 / R9: per line, per mode, per direction
    for (int i = 0; i < 4; i++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int rise = 0; rise < 2; rise++) begin
          int base, exp_ev;
          base = (rise == 1) ? 0 : (1 << i);
          exp_ev = (rise == 1) ? ((mode >> 1) & 1) : (mode & 1);
          wr(3'd3, 8'h00);
          gpi = 4'(base);
          repeat (4) nxt();
          clear_all();
          wr(3'd3, 8'(mode << (2 * i)));
          gpi = 4'(base ^ (1 << i));
          nxt(); nxt();
          rd(3'd4, v); check("R6 not yet after two edges", v, 0);
          nxt();
          rd(3'd4, v); check("R5 R6 event by mode", v, exp_ev << i);
          check("R9 irq follows status", irq, exp_ev);
          wr(3'd4, v);
          rd(3'd4, v); check("R7 cleared", v, 0);
          check("R9 irq after clear", irq, 0);
        end
      end
    end
    wr(3'd3, 8'h00); gpi = 4'h0; repeat (4) nxt(); clear_all();

    // R7: partial clear, zeros keep bits, upper bits ignored
    wr(3'd3, 8'hAA);
    gpi = 4'hF; repeat (3) nxt();
    rd(3'd4, v); check("R6 all rising", v, 8'h0F);
    wr(3'd4, 8'hF5); rd(3'd4, v); check("R7 partial clear", v, 8'h0A);
    check("R9 irq still on", irq, 1);
    wr(3'd4, 8'h00); rd(3'd4, v); check("R7 zero write keeps", v, 8'h0A);
    wr(3'd4, 8'h0A); rd(3'd4, v); check("R7 rest cleared", v, 0);
    check("R9 irq off after clear", irq, 0);

    // R8: set wins over same-cycle clear
    wr(3'd3, 8'h30);  // both edges on input 2
    gpi = 4'hB; repeat (3) nxt();
    rd(3'd4, v); check("R8 setup pending", v, 8'h04);
    gpi = 4'hF;
    nxt(); nxt();
    addr = 3'd4; wdata = 8'h04; wr_en = 1'b1;
    nxt(); wr_en = 1'b0;
    rd(3'd4, v); check("R8 set wins", v, 8'h04);
    wr(3'd4, 8'h04); rd(3'd4, v); check("R8 later clear", v, 0);

    // R10: masking keeps pending bits, blocks new ones
    gpi = 4'hB; repeat (3) nxt();
    rd(3'd4, v); check("R10 pending before mask", v, 8'h04);
    wr(3'd3, 8'h00);
    gpi = 4'h0; repeat (4) nxt();
    rd(3'd4, v); check("R10 no new events", v, 8'h04);
    check("R10 irq held", irq, 1);
    wr(3'd4, 8'h04); rd(3'd4, v); check("R10 clear after mask", v, 0);
    gpi = 4'hF; repeat (4) nxt();
    rd(3'd4, v); check("R10 masked rise", v, 0);
    gpi = 4'h0; repeat (4) nxt();

    // R11: unused offsets
    wr(3'd1, 8'h06); wr(3'd3, 8'h5A);
    for (int a = 2; a < 8; a++) begin
      if (a == 3 || a == 4) continue;
      wr(3'(a), 8'hFF);
      rd(3'(a), v); check("R11 unused reads zero", v, 0);
    end
    rd(3'd1, v); check("R11 data untouched", v, 8'h06);
    rd(3'd3, v); check("R11 cfg untouched", v, 8'h5A);
    rd(3'd4, v); check("R11 status untouched", v, 0);
    addr = 3'd0; rd_en = 1'b0; #1; check("R11 idle read zero", rdata, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule